// File: doc/BRIEF.md
# SPI Host Register Front-End

This block sits between a processor's 32-bit register port and an SPI command sequencer. Software pushes 16-bit command words and outgoing data bytes through two write ports. It pops incoming bytes through a read port. It polls free space and fill level through dedicated registers. The sequencer side consists of three plain streams and one event input: a command stream, an outgoing byte stream, an incoming byte stream, and a sync strobe that carries an 8-bit tag.

Interrupts come from four sources:
- three FIFO watermarks, which are level-sensitive and follow the FIFO fill state;
- one sticky sync flag, which records that the sequencer reached a tagged marker.

The tag of the most recent marker is latched. Software can compare it with the tag it queued and so match a completion to a message. A soft-reset register holds the FIFOs empty and drives a reset output to the sequencer.

Top module: `spi_host_regfe`

## Requirements
- R1: Offset 0x00 reads `{8'h00, major, minor, patch}` from parameters, and major defaults to 1.
- R2: Writing 1 to bit 0 of offset 0x40 empties all three FIFOs, drives `engine_rst_o` high, ignores pushes and sync events, and keeps the sync flag clear. Writing 0 to the same bit releases the block.
- R3: Writes to 0xE0 queue bits [15:0] of the write data as a command word. Command words leave on the command stream in write order, one per cycle when `cmd_valid_o` and `cmd_ready_i` are both high.
- R4: Writes to 0xE4 queue bits [7:0] of the write data as an outgoing byte. Outgoing bytes leave in write order on the outgoing stream.
- R5: A read of 0xE8 returns the oldest incoming byte and removes it. A read of 0xEC returns that byte and leaves the FIFO unchanged.
- R6: Offset 0xD0 reads the free command entries, 0xD4 reads the free outgoing entries, and 0xD8 reads the incoming fill level.
- R7: A push to a full FIFO is dropped. A read of 0xE8 or 0xEC on an empty incoming FIFO returns 0 and leaves the level unchanged.
- R8: Pending bits 0, 1 and 2 are live conditions, and read back at offset 0x84:
  - bit 0 is set when command level ≤ `CMD_AE_THR`;
  - bit 1 is set when outgoing level ≤ `SDO_AE_THR`;
  - bit 2 is set when incoming level ≥ `SDI_AF_THR`.
- R9: A sync strobe sets pending bit 3 and latches its tag, which reads at 0xC0. Writing a 1 to bit 3 of 0x84 clears the flag, writing a 0 there leaves it set, and a strobe in the same cycle as the clear wins.
- R10: Offset 0x80 holds the 4-bit enable. Offset 0x88 reads pending AND enable. `irq_o` is a register loaded each cycle with the OR of pending AND enable.
- R11: `sdi_ready_o` is low while the incoming FIFO is full. A byte offered in that state is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid |
| cmd_valid_o | output | 1 | Command word available |
| cmd_data_o | output | 16 | Head command word |
| cmd_ready_i | input | 1 | Sequencer takes the command word |
| sdo_valid_o | output | 1 | Outgoing byte available |
| sdo_data_o | output | 8 | Head outgoing byte |
| sdo_ready_i | input | 1 | Sequencer takes the outgoing byte |
| sdi_valid_i | input | 1 | Incoming byte offered |
| sdi_data_i | input | 8 | Incoming byte |
| sdi_ready_o | output | 1 | Incoming FIFO can accept |
| sync_valid_i | input | 1 | Sync marker reached |
| sync_id_i | input | 8 | Tag of the marker |
| engine_rst_o | output | 1 | Soft reset towards the sequencer |
| irq_o | output | 1 | Interrupt request |

## Verification
The FIFO assertions assume that the sequencer only asserts a ready when the matching valid is high. The bench pulses each ready only after it has seen valid and checked the head value.

The sync assertions assume that a strobe is a single-cycle pulse whose tag is stable in that cycle. The bench drives each strobe for exactly one clock.

The near-exhaustive sweeps fill every FIFO one entry past full. After each push they compare the room, level and watermark bits with values computed from the depth and thresholds. The sweeps only issue a register access after the previous one has returned, so no pop and read of the same FIFO overlap.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] A_VERSION  = 8'h00;
  localparam logic [REG_ADDR_W-1:0] A_SOFT_RST = 8'h40;
  localparam logic [REG_ADDR_W-1:0] A_IRQ_EN   = 8'h80;
  localparam logic [REG_ADDR_W-1:0] A_IRQ_PEND = 8'h84;
  localparam logic [REG_ADDR_W-1:0] A_IRQ_SRC  = 8'h88;
  localparam logic [REG_ADDR_W-1:0] A_SYNC_ID  = 8'hC0;
  localparam logic [REG_ADDR_W-1:0] A_CMD_ROOM = 8'hD0;
  localparam logic [REG_ADDR_W-1:0] A_SDO_ROOM = 8'hD4;
  localparam logic [REG_ADDR_W-1:0] A_SDI_LVL  = 8'hD8;
  localparam logic [REG_ADDR_W-1:0] A_CMD_PUSH = 8'hE0;
  localparam logic [REG_ADDR_W-1:0] A_SDO_PUSH = 8'hE4;
  localparam logic [REG_ADDR_W-1:0] A_SDI_POP  = 8'hE8;
  localparam logic [REG_ADDR_W-1:0] A_SDI_PEEK = 8'hEC;

  localparam int IRQ_N      = 4;
  localparam int IRQ_CMD_AE = 0;
  localparam int IRQ_SDO_AE = 1;
  localparam int IRQ_SDI_AF = 2;
  localparam int IRQ_SYNC   = 3;

  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           head_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  // empty head reads as zero
  assign head_o  = empty_o ? '0 : mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  AST_FULL_PUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> $stable(cnt_q)); // R7
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> $stable(cnt_q)); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R6
endmodule

// File: rtl/spi_fe_irq.sv
module spi_fe_irq
  import spi_fe_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [IRQ_N-2:0] wmark_i,
  input  logic             sync_set_i,
  input  logic [ID_W-1:0]  sync_id_i,
  input  logic             en_we_i,
  input  irq_vec_t         en_wdata_i,
  input  logic             w1c_we_i,
  input  irq_vec_t         w1c_i,
  output irq_vec_t         pend_o,
  output irq_vec_t         en_o,
  output irq_vec_t         src_o,
  output logic [ID_W-1:0]  sync_id_o,
  output logic             irq_o
);
  irq_vec_t        en_q;
  logic            sync_q;
  logic [ID_W-1:0] id_q;
  logic            irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  // set beats clear, soft reset beats both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sync_q <= 1'b0;
    else if (clr_i)                       sync_q <= 1'b0;
    else if (sync_set_i)                  sync_q <= 1'b1;
    else if (w1c_we_i && w1c_i[IRQ_SYNC]) sync_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) id_q <= '0;
    else if (sync_set_i && !clr_i) id_q <= sync_id_i;
  end

  assign pend_o = {sync_q, wmark_i};
  assign src_o  = pend_o & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |src_o;
  end

  assign en_o      = en_q;
  assign sync_id_o = id_q;
  assign irq_o     = irq_q;

  AST_SYNC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_set_i && !clr_i) |=> sync_q); // R9
  AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && !clr_i && !(w1c_we_i && w1c_i[IRQ_SYNC])) |=> sync_q); // R9
  AST_SYNC_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_set_i && !clr_i) |=> (id_q == $past(sync_id_i))); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o); // R10
endmodule

// File: rtl/spi_host_regfe.sv
module spi_host_regfe
  import spi_fe_pkg::*;
#(
  parameter int         CMD_DEPTH  = 16,
  parameter int         SDO_DEPTH  = 16,
  parameter int         SDI_DEPTH  = 16,
  parameter int         CMD_AE_THR = CMD_DEPTH / 4,
  parameter int         SDO_AE_THR = SDO_DEPTH / 4,
  parameter int         SDI_AF_THR = (3 * SDI_DEPTH) / 4,
  parameter logic [7:0] VER_MAJOR  = 8'd1,
  parameter logic [7:0] VER_MINOR  = 8'd0,
  parameter logic [7:0] VER_PATCH  = 8'd0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        bus_rvalid_o,
  output logic        cmd_valid_o,
  output logic [15:0] cmd_data_o,
  input  logic        cmd_ready_i,
  output logic        sdo_valid_o,
  output logic [7:0]  sdo_data_o,
  input  logic        sdo_ready_i,
  input  logic        sdi_valid_i,
  input  logic [7:0]  sdi_data_i,
  output logic        sdi_ready_o,
  input  logic        sync_valid_i,
  input  logic [7:0]  sync_id_i,
  output logic        engine_rst_o,
  output logic        irq_o
);
  localparam int CMD_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 8;
  localparam int CMD_LW = $clog2(CMD_DEPTH+1);
  localparam int SDO_LW = $clog2(SDO_DEPTH+1);
  localparam int SDI_LW = $clog2(SDI_DEPTH+1);
  localparam logic [31:0] VERSION_WORD = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};

  logic wr, rd;
  logic soft_rst_q;
  logic [31:0] rdata_q, rdata_d;
  logic rvalid_q;
  logic unused_wdata;

  logic [CMD_LW-1:0] cmd_lvl;
  logic [SDO_LW-1:0] sdo_lvl;
  logic [SDI_LW-1:0] sdi_lvl;
  logic cmd_full, cmd_empty, sdo_full, sdo_empty, sdi_full, sdi_empty;
  logic [BYTE_W-1:0] sdi_head;
  logic cmd_push, sdo_push, sdi_push, sdi_pop;

  irq_vec_t pend, en, src;
  logic [IRQ_N-2:0] wmark;
  logic [ID_W-1:0] last_id;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;
  assign unused_wdata = ^bus_wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_rst_q <= 1'b0;
    else if (wr && bus_addr_i == A_SOFT_RST) soft_rst_q <= bus_wdata_i[0];
  end
  assign engine_rst_o = soft_rst_q;

  assign cmd_push = wr && (bus_addr_i == A_CMD_PUSH) && !soft_rst_q;
  assign sdo_push = wr && (bus_addr_i == A_SDO_PUSH) && !soft_rst_q;
  assign sdi_push = sdi_valid_i && !soft_rst_q;
  assign sdi_pop  = rd && (bus_addr_i == A_SDI_POP);

  spi_fe_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) cmd_fifo_i (
    .clk_i, .rst_ni, .clr_i(soft_rst_q),
    .push_i(cmd_push), .wdata_i(bus_wdata_i[CMD_W-1:0]),
    .pop_i(cmd_ready_i), .head_o(cmd_data_o), .level_o(cmd_lvl),
    .full_o(cmd_full), .empty_o(cmd_empty)
  );

  spi_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(SDO_DEPTH)) sdo_fifo_i (
    .clk_i, .rst_ni, .clr_i(soft_rst_q),
    .push_i(sdo_push), .wdata_i(bus_wdata_i[BYTE_W-1:0]),
    .pop_i(sdo_ready_i), .head_o(sdo_data_o), .level_o(sdo_lvl),
    .full_o(sdo_full), .empty_o(sdo_empty)
  );

  spi_fe_fifo #(.WIDTH(BYTE_W), .DEPTH(SDI_DEPTH)) sdi_fifo_i (
    .clk_i, .rst_ni, .clr_i(soft_rst_q),
    .push_i(sdi_push), .wdata_i(sdi_data_i),
    .pop_i(sdi_pop), .head_o(sdi_head), .level_o(sdi_lvl),
    .full_o(sdi_full), .empty_o(sdi_empty)
  );

  assign cmd_valid_o = ~cmd_empty;
  assign sdo_valid_o = ~sdo_empty;
  assign sdi_ready_o = ~sdi_full & ~soft_rst_q;

  assign wmark[IRQ_CMD_AE] = (cmd_lvl <= CMD_LW'(CMD_AE_THR));
  assign wmark[IRQ_SDO_AE] = (sdo_lvl <= SDO_LW'(SDO_AE_THR));
  assign wmark[IRQ_SDI_AF] = (sdi_lvl >= SDI_LW'(SDI_AF_THR));

  spi_fe_irq #(.ID_W(ID_W)) irq_i (
    .clk_i, .rst_ni, .clr_i(soft_rst_q),
    .wmark_i(wmark),
    .sync_set_i(sync_valid_i), .sync_id_i(sync_id_i),
    .en_we_i(wr && bus_addr_i == A_IRQ_EN), .en_wdata_i(bus_wdata_i[IRQ_N-1:0]),
    .w1c_we_i(wr && bus_addr_i == A_IRQ_PEND), .w1c_i(bus_wdata_i[IRQ_N-1:0]),
    .pend_o(pend), .en_o(en), .src_o(src), .sync_id_o(last_id), .irq_o(irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_VERSION:              rdata_d = VERSION_WORD;
      A_SOFT_RST:             rdata_d = 32'(soft_rst_q);
      A_IRQ_EN:               rdata_d = 32'(en);
      A_IRQ_PEND:             rdata_d = 32'(pend);
      A_IRQ_SRC:              rdata_d = 32'(src);
      A_SYNC_ID:              rdata_d = 32'(last_id);
      A_CMD_ROOM:             rdata_d = 32'(CMD_LW'(CMD_DEPTH) - cmd_lvl);
      A_SDO_ROOM:             rdata_d = 32'(SDO_LW'(SDO_DEPTH) - sdo_lvl);
      A_SDI_LVL:              rdata_d = 32'(sdi_lvl);
      A_SDI_POP, A_SDI_PEEK:  rdata_d = 32'(sdi_head);
      default:                rdata_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  AST_RST_DRAINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(soft_rst_q) && soft_rst_q) |-> (!cmd_valid_o && !sdo_valid_o && sdi_empty)); // R2
  AST_RST_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_q && $past(soft_rst_q)) |=> (cmd_lvl == '0)); // R2
  AST_SDI_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdi_full && !sdi_pop && !soft_rst_q) |=> $stable(sdi_lvl)); // R11
  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> bus_rvalid_o); // R6
  AST_FULL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_full && cmd_empty) && !(sdo_full && sdo_empty)); // R7
endmodule

// File: tb/spi_host_regfe_tb_top.sv
module spi_host_regfe_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DEPTH = 8;
  localparam int  AE = DEPTH / 4;
  localparam int  AF = (3 * DEPTH) / 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic cmd_valid, cmd_ready = 0, sdo_valid, sdo_ready = 0;
  logic [15:0] cmd_data;
  logic [7:0] sdo_data, sdi_data = '0, sync_id = '0;
  logic sdi_valid = 0, sdi_ready, sync_valid = 0, engine_rst, irq;

  int n_checks = 0;
  int n_errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_regfe #(
    .CMD_DEPTH(DEPTH), .SDO_DEPTH(DEPTH), .SDI_DEPTH(DEPTH),
    .VER_MINOR(8'h05), .VER_PATCH(8'h61)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready),
    .sdo_valid_o(sdo_valid), .sdo_data_o(sdo_data), .sdo_ready_i(sdo_ready),
    .sdi_valid_i(sdi_valid), .sdi_data_i(sdi_data), .sdi_ready_o(sdi_ready),
    .sync_valid_i(sync_valid), .sync_id_i(sync_id),
    .engine_rst_o(engine_rst), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata;
  endtask

  task automatic sdi_put(input logic [7:0] b);
    @(negedge clk);
    sdi_valid = 1; sdi_data = b;
    @(negedge clk);
    sdi_valid = 0;
  endtask

  task automatic sync_put(input logic [7:0] t);
    @(negedge clk);
    sync_valid = 1; sync_id = t;
    @(negedge clk);
    sync_valid = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // reset state
    rd(8'h00, d); chk("R1 version", d, 32'h0001_0561);
    rd(8'hD0, d); chk("R6 cmd room at reset", d, DEPTH);
    rd(8'hD4, d); chk("R6 sdo room at reset", d, DEPTH);
    rd(8'hD8, d); chk("R6 sdi level at reset", d, 0);
    rd(8'h84, d); chk("R8 pending at reset", d, 32'h3);
    chk("R10 irq at reset", irq, 0);
    chk("R2 engine_rst at reset", engine_rst, 0);

    // command FIFO sweep, one past full
    for (int k = 1; k <= DEPTH + 1; k++) begin
      int lvl;
      lvl = (k > DEPTH) ? DEPTH : k;
      wr(8'hE0, 32'hFFFF_A000 | k);
      rd(8'hD0, d); chk("R6/R7 cmd room", d, DEPTH - lvl);
      rd(8'h84, d); chk("R8 cmd almost empty", d[0], (lvl <= AE));
    end
    for (int k = 1; k <= DEPTH; k++) begin
      @(negedge clk);
      chk("R3 cmd valid", cmd_valid, 1);
      chk("R3 cmd order", cmd_data, 16'hA000 + k);
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
    end
    chk("R7 cmd overflow dropped", cmd_valid, 0);

    // outgoing FIFO sweep
    for (int k = 1; k <= DEPTH + 1; k++) begin
      int lvl;
      lvl = (k > DEPTH) ? DEPTH : k;
      wr(8'hE4, 32'hDEAD_BE10 + k);
      rd(8'hD4, d); chk("R6/R7 sdo room", d, DEPTH - lvl);
      rd(8'h84, d); chk("R8 sdo almost empty", d[1], (lvl <= AE));
    end
    for (int k = 1; k <= DEPTH; k++) begin
      @(negedge clk);
      chk("R4 sdo valid", sdo_valid, 1);
      chk("R4 sdo order", sdo_data, 8'h10 + k);
      sdo_ready = 1;
      @(negedge clk);
      sdo_ready = 0;
    end
    chk("R7 sdo overflow dropped", sdo_valid, 0);

    // incoming FIFO sweep
    for (int k = 1; k <= DEPTH + 1; k++) begin
      int lvl;
      lvl = (k > DEPTH) ? DEPTH : k;
      @(negedge clk);
      chk("R11 sdi ready", sdi_ready, (k <= DEPTH));
      sdi_put(8'h40 + k);
      rd(8'hD8, d); chk("R6 sdi level", d, lvl);
      rd(8'h84, d); chk("R8 sdi almost full", d[2], (lvl >= AF));
    end
    rd(8'hEC, d); chk("R5 peek head", d, 8'h41);
    rd(8'hD8, d); chk("R5 peek keeps level", d, DEPTH);
    for (int k = 1; k <= DEPTH; k++) begin
      rd(8'hE8, d); chk("R5 pop order", d, 8'h40 + k);
    end
    rd(8'hE8, d); chk("R7 empty pop zero", d, 0);
    rd(8'hEC, d); chk("R7 empty peek zero", d, 0);
    rd(8'hD8, d); chk("R7 empty level kept", d, 0);

    // sync flag and id
    wr(8'h80, 32'h8);
    rd(8'h80, d); chk("R10 enable readback", d, 32'h8);
    chk("R10 irq idle", irq, 0);
    sync_put(8'h5A);
    repeat (2) @(negedge clk);
    chk("R10 irq on sync", irq, 1);
    rd(8'hC0, d); chk("R9 sync id", d, 32'h5A);
    rd(8'h84, d); chk("R9 pending with sync", d, 32'hB);
    rd(8'h88, d); chk("R10 source masked", d, 32'h8);
    wr(8'h84, 32'h7);
    rd(8'h84, d); chk("R9 zero write keeps flag", d[3], 1);
    wr(8'h84, 32'h8);
    rd(8'h84, d); chk("R9 w1c clears", d[3], 0);
    repeat (2) @(negedge clk);
    chk("R10 irq drops", irq, 0);
    // strobe and clear in the same cycle
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 8'h84; bus_wdata = 32'h8;
    sync_valid = 1; sync_id = 8'h33;
    @(negedge clk);
    bus_req = 0; bus_we = 0; sync_valid = 0;
    rd(8'h84, d); chk("R9 set wins over clear", d[3], 1);
    rd(8'hC0, d); chk("R9 second sync id", d, 32'h33);
    wr(8'h84, 32'h8);

    // watermark interrupt
    wr(8'h80, 32'h1);
    repeat (2) @(negedge clk);
    chk("R10 irq cmd almost empty", irq, 1);
    for (int k = 0; k < AE + 1; k++) wr(8'hE0, 32'h100 + k);
    repeat (2) @(negedge clk);
    chk("R10 irq follows level", irq, 0);
    rd(8'h88, d); chk("R10 source clear", d, 0);

    // soft reset
    wr(8'h40, 32'h1);
    @(negedge clk);
    chk("R2 engine_rst high", engine_rst, 1);
    rd(8'h40, d); chk("R2 reset readback", d, 1);
    rd(8'hD0, d); chk("R2 cmd flushed", d, DEPTH);
    wr(8'hE0, 32'h1234);
    rd(8'hD0, d); chk("R2 push ignored", d, DEPTH);
    sync_put(8'h77);
    rd(8'h84, d); chk("R2 sync ignored", d[3], 0);
    chk("R2 sdi not ready", sdi_ready, 0);
    wr(8'h40, 32'h0);
    @(negedge clk);
    chk("R2 engine_rst released", engine_rst, 0);
    chk("R2 cmd empty after release", cmd_valid, 0);
    wr(8'hE0, 32'h4321);
    rd(8'hD0, d); chk("R2 push after release", d, DEPTH - 1);
    @(negedge clk);
    chk("R3 cmd after release", cmd_data, 16'h4321);

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule